// File: doc/BRIEF.md
# Low-Side Driver Reset and Enable Controller

This block decides, every clock cycle, whether each of six independent low-side gate outputs may follow its command. It also decides whether the serial slave and the open-drain fault flag may run. It takes three control sources. The first is an active-high power-on reset. The second is an active-low reset pin. The third is an active-low global enable pin. Both pins pass through a two-stage synchronizer before the control logic uses them. The assert side of either reset also forces the gate outputs low at once, without waiting for a clock edge.

Reset and enable play different roles. Reset wipes everything: it raises the register-initialise and status-clear strobes, stops the serial slave, the fault flag and the timer clock, and clears all latched fault data. The enable pin only parks the outputs. While it is inactive, the gates are off, diagnostics are ignored and the auto-retry timer is held in reset. Settings, fault status and the serial slave are left untouched. When the enable returns, every channel that a fault shut off is re-armed.

Top module: `lsd_rst_en_ctrl`

## Requirements
- R1: While `por_i` is 1, `gate_o` is 0 on all channels with no clock edge needed. `flag_en_o` and `spi_en_o` are 0, and `reg_init_o` and `status_clr_o` are 1.
- R2: As soon as `rst_pin_n_i` goes 0, `gate_o` is 0 with no clock edge needed. Within six cycles, `spi_en_o`, `flag_en_o` and `timer_clk_en_o` are 0, and `reg_init_o` and `status_clr_o` are 1.
- R3: Within six cycles of `rst_pin_n_i` returning to 1 (with `por_i` at 0), `spi_en_o`, `flag_en_o` and `timer_clk_en_o` are 1, and both strobes are 0.
- R4: While `en_pin_n_i` is 1, `gate_o` is all zeros, `diag_en_o` is 0 and `retry_rst_o` is 1.
- R5: While `en_pin_n_i` is 1, `spi_en_o` stays 1.
- R6: When `en_pin_n_i` falls to 0, every channel whose shutdown bit in `shut_o` is set has that bit cleared. That channel's gate then follows its command again.
- R7: Out of reset and enabled, bit k of `gate_o` equals bit k of `cmd_i` ANDed with the inverse of bit k of `shut_o`. Each channel is independent of the others.
- R8: A 1 on bit k of `fault_i` while diagnostics are enabled sets bit k of both `fault_stat_o` and `shut_o`. While `en_pin_n_i` is 1, `fault_i` has no effect on either.
- R9: Reset overrides enable. While in reset, the gates stay off even with `en_pin_n_i` at 0, and after reset `fault_stat_o` and `shut_o` read all zeros.
- R10: `fault_stat_o` bits are cleared only by reset. Toggling the enable pin leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, active high |
| rst_pin_n_i | input | 1 | External reset pin, active low, asynchronous |
| en_pin_n_i | input | 1 | Global enable pin, active low, asynchronous |
| cmd_i | input | NUM_CH | Per-channel gate command |
| fault_i | input | NUM_CH | Per-channel fault detect pulses |
| gate_o | output | NUM_CH | Gate-enable mask to the drivers |
| fault_stat_o | output | NUM_CH | Sticky fault status per channel |
| shut_o | output | NUM_CH | Channels currently shut off by a fault |
| spi_en_o | output | 1 | Serial slave enable |
| flag_en_o | output | 1 | Fault flag output enable |
| timer_clk_en_o | output | 1 | Timer clock enable |
| diag_en_o | output | 1 | Diagnostics enable |
| retry_rst_o | output | 1 | Auto-retry timer reset |
| reg_init_o | output | 1 | Register initialise strobe, high during reset |
| status_clr_o | output | 1 | Status clear strobe, high during reset |

## Verification
The gate mask is driven with all ones and with two complementary sparse command patterns. This separates a real per-channel AND from any cross-channel coupling. A single-channel fault then shows that only that channel drops out, while the others keep following their commands. The enable pin is then cycled with a fault pulse applied while it is off. This separates the shutdown latch, which re-arms, from the sticky status, which is kept, and shows that fault input is ignored while disabled. Finally the reset pin is asserted with the enable active. This shows that the gates drop in the same cycle and that reset, not the enable, decides the outcome.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  localparam int unsigned CH_DEFAULT   = 6;
  localparam int unsigned SYNC_DEFAULT = 2;

  typedef struct packed {
    logic in_rst;
    logic en_act;
  } ctl_state_t;
endpackage

// File: rtl/rgc_sync.sv
module rgc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic srst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (srst) sh <= {STAGES{RST_VAL}};
    else      sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rgc_chan.sv
module rgc_chan (
  input  logic clk,
  input  logic rst_i,
  input  logic diag_on_i,
  input  logic rearm_i,
  input  logic gate_ok_i,
  input  logic cmd_i,
  input  logic fault_i,
  output logic gate_o,
  output logic stat_o,
  output logic shut_o
);
  logic gate_q, stat_q, shut_q;
  logic hit;

  assign hit = fault_i & diag_on_i;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      gate_q <= 1'b0;
      stat_q <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      stat_q <= stat_q | hit;
      shut_q <= (shut_q & ~rearm_i) | hit;
      gate_q <= cmd_i & ~shut_q & gate_ok_i;
    end
  end

  assign gate_o = gate_q;
  assign stat_o = stat_q;
  assign shut_o = shut_q;

  // R7: a gate can only be on if it was commanded the cycle before
  p_gate_needs_cmd_r7: assert property (@(posedge clk) disable iff (rst_i)
    gate_q |-> $past(cmd_i));
  // R8: a shut channel drives no gate on the following cycle
  p_shut_blocks_gate_r8: assert property (@(posedge clk) disable iff (rst_i)
    shut_q |=> !gate_q);
  // R10: sticky status never falls outside reset
  p_stat_sticky_r10: assert property (@(posedge clk) disable iff (rst_i)
    stat_q |=> stat_q);
endmodule

// File: rtl/lsd_rst_en_ctrl.sv
module lsd_rst_en_ctrl #(
  parameter int unsigned NUM_CH      = rgc_pkg::CH_DEFAULT,
  parameter int unsigned SYNC_STAGES = rgc_pkg::SYNC_DEFAULT
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              rst_pin_n_i,
  input  logic              en_pin_n_i,
  input  logic [NUM_CH-1:0] cmd_i,
  input  logic [NUM_CH-1:0] fault_i,
  output logic [NUM_CH-1:0] gate_o,
  output logic [NUM_CH-1:0] fault_stat_o,
  output logic [NUM_CH-1:0] shut_o,
  output logic              spi_en_o,
  output logic              flag_en_o,
  output logic              timer_clk_en_o,
  output logic              diag_en_o,
  output logic              retry_rst_o,
  output logic              reg_init_o,
  output logic              status_clr_o
);
  import rgc_pkg::*;

  localparam logic [NUM_CH-1:0] ALL_OFF = '0;

  logic rst_s, en_s;
  logic raw_rst;
  logic en_prev;
  logic rearm;
  logic diag_on;
  logic gate_ok;
  ctl_state_t st;
  logic [NUM_CH-1:0] gate_q;

  rgc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .srst(por_i), .d(rst_pin_n_i), .q(rst_s));

  rgc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
    .clk(clk), .srst(por_i), .d(en_pin_n_i), .q(en_s));

  assign st.in_rst = por_i | ~rst_s;
  assign st.en_act = ~en_s;
  assign raw_rst   = por_i | ~rst_pin_n_i;
  assign diag_on   = ~st.in_rst & st.en_act;
  assign gate_ok   = ~st.in_rst & st.en_act;
  assign rearm     = st.en_act & ~en_prev;

  always_ff @(posedge clk) begin
    if (st.in_rst) begin
      en_prev        <= 1'b0;
      spi_en_o       <= 1'b0;
      flag_en_o      <= 1'b0;
      timer_clk_en_o <= 1'b0;
      diag_en_o      <= 1'b0;
      retry_rst_o    <= 1'b1;
      reg_init_o     <= 1'b1;
      status_clr_o   <= 1'b1;
    end else begin
      en_prev        <= st.en_act;
      spi_en_o       <= 1'b1;
      flag_en_o      <= 1'b1;
      timer_clk_en_o <= 1'b1;
      diag_en_o      <= st.en_act;
      retry_rst_o    <= ~st.en_act;
      reg_init_o     <= 1'b0;
      status_clr_o   <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    rgc_chan u_chan (
      .clk      (clk),
      .rst_i    (st.in_rst),
      .diag_on_i(diag_on),
      .rearm_i  (rearm),
      .gate_ok_i(gate_ok),
      .cmd_i    (cmd_i[k]),
      .fault_i  (fault_i[k]),
      .gate_o   (gate_q[k]),
      .stat_o   (fault_stat_o[k]),
      .shut_o   (shut_o[k])
    );
  end

  // The assert side of reset bypasses every flop
  assign gate_o = raw_rst ? ALL_OFF : gate_q;

  // R1 / R2: gates low the moment either reset source is asserted
  always_comb begin
    if (raw_rst) p_gate_off_raw_rst_r2: assert (gate_o == ALL_OFF);
  end
  // R2: serial slave stopped one cycle into internal reset
  p_spi_off_in_reset_r2: assert property (@(posedge clk) disable iff (por_i)
    st.in_rst |=> !spi_en_o);
  // R4: disabled chip drives no gate in the next cycle
  p_gate_off_disabled_r4: assert property (@(posedge clk) disable iff (st.in_rst)
    !st.en_act |=> (gate_o == ALL_OFF));
  // R5: enable pin never takes the serial slave down
  p_spi_kept_r5: assert property (@(posedge clk) disable iff (st.in_rst)
    (spi_en_o && !st.en_act) |=> spi_en_o);
  // R6: an enable rising edge leaves no channel shut unless a new fault hit
  p_rearm_r6: assert property (@(posedge clk) disable iff (st.in_rst)
    (rearm && ((fault_i & {NUM_CH{diag_on}}) == ALL_OFF)) |=> (shut_o == ALL_OFF));
endmodule

// File: tb/lsd_rst_en_ctrl_test.sv
module lsd_rst_en_ctrl_test;
  localparam int N = 6;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic por_i = 1'b1, rst_pin_n_i = 1'b1, en_pin_n_i = 1'b0;
  logic [N-1:0] cmd_i = '0, fault_i = '0;
  logic [N-1:0] gate_o, fault_stat_o, shut_o;
  logic spi_en_o, flag_en_o, timer_clk_en_o, diag_en_o, retry_rst_o;
  logic reg_init_o, status_clr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsd_rst_en_ctrl #(.NUM_CH(N), .SYNC_STAGES(2)) uut (
    .clk(clk), .por_i(por_i), .rst_pin_n_i(rst_pin_n_i), .en_pin_n_i(en_pin_n_i),
    .cmd_i(cmd_i), .fault_i(fault_i), .gate_o(gate_o), .fault_stat_o(fault_stat_o),
    .shut_o(shut_o), .spi_en_o(spi_en_o), .flag_en_o(flag_en_o),
    .timer_clk_en_o(timer_clk_en_o), .diag_en_o(diag_en_o), .retry_rst_o(retry_rst_o),
    .reg_init_o(reg_init_o), .status_clr_o(status_clr_o));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_fault(input logic [N-1:0] m);
    @(negedge clk); fault_i = m;
    @(negedge clk); fault_i = '0;
  endtask

  task automatic t_por();
    wait_cyc(4);
    cmd_i = ALL;
    #1;
    chk("R1 gate off in POR", gate_o, '0);
    chk("R1 flag off", {5'b0, flag_en_o}, 6'd0);
    chk("R1 spi off", {5'b0, spi_en_o}, 6'd0);
    chk("R1 strobes", {4'b0, reg_init_o, status_clr_o}, 6'b000011);
    @(negedge clk); por_i = 1'b0;
    wait_cyc(6);
    chk("R3 spi/flag/timer on", {3'b0, spi_en_o, flag_en_o, timer_clk_en_o}, 6'b000111);
    chk("R3 strobes low", {4'b0, reg_init_o, status_clr_o}, 6'b0);
    chk("R7 all commanded", gate_o, ALL);
  endtask

  task automatic t_pattern();
    cmd_i = 6'b101001; wait_cyc(3);
    chk("R7 pattern A", gate_o, 6'b101001);
    cmd_i = 6'b010110; wait_cyc(3);
    chk("R7 pattern B", gate_o, 6'b010110);
    cmd_i = ALL; wait_cyc(3);
  endtask

  task automatic t_fault();
    pulse_fault(6'b000100);
    wait_cyc(3);
    chk("R8 status set", fault_stat_o, 6'b000100);
    chk("R8 shut set", shut_o, 6'b000100);
    chk("R7 others unaffected", gate_o, 6'b111011);
  endtask

  task automatic t_enable();
    @(negedge clk); en_pin_n_i = 1'b1;
    wait_cyc(5);
    chk("R4 gates off", gate_o, '0);
    chk("R4 diag off retry rst", {4'b0, diag_en_o, retry_rst_o}, 6'b000001);
    chk("R5 spi kept", {5'b0, spi_en_o}, 6'd1);
    pulse_fault(6'b000001);
    wait_cyc(3);
    chk("R8 fault ignored when disabled", fault_stat_o, 6'b000100);
    @(negedge clk); en_pin_n_i = 1'b0;
    wait_cyc(6);
    chk("R6 shut cleared", shut_o, '0);
    chk("R6 gates re-armed", gate_o, ALL);
    chk("R10 status kept", fault_stat_o, 6'b000100);
    chk("R4 retry released", {5'b0, retry_rst_o}, 6'd0);
  endtask

  task automatic t_rstpin();
    pulse_fault(6'b100000);
    wait_cyc(3);
    chk("R8 second fault", fault_stat_o, 6'b100100);
    @(negedge clk); rst_pin_n_i = 1'b0;
    #1;
    chk("R2 immediate gate off", gate_o, '0);
    wait_cyc(6);
    chk("R2 spi/flag/timer off", {3'b0, spi_en_o, flag_en_o, timer_clk_en_o}, 6'b0);
    chk("R2 strobes high", {4'b0, reg_init_o, status_clr_o}, 6'b000011);
    chk("R9 reset beats enable", gate_o, '0);
    @(negedge clk); rst_pin_n_i = 1'b1;
    wait_cyc(6);
    chk("R9 status cleared", fault_stat_o, '0);
    chk("R9 shut cleared", shut_o, '0);
    chk("R3 spi/flag back", {4'b0, spi_en_o, flag_en_o}, 6'b000011);
    chk("R7 running after reset", gate_o, ALL);
    @(negedge clk); por_i = 1'b1;
    #1;
    chk("R1 POR immediate gate off", gate_o, '0);
    @(negedge clk); por_i = 1'b0;
  endtask

  initial begin
    t_por();
    t_pattern();
    t_fault();
    t_enable();
    t_rstpin();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule